// File: doc/BRIEF.md
# One-Wire Bit Slot Engine

This block runs one bit time slot on an open-drain single-wire bus. A host raises a start strobe together with a read/write select and, for writes, a data bit. The engine then releases the bus for a recovery interval and pulls the line low for a width chosen by the slot kind. For a read slot it samples the line late in the valid window. When the slot ends it pulses a done strobe and presents the read bit.

All timing is counted in microsecond ticks from a clock prescaler, so every pulse width is an exact multiple of the tick. The bus side has two signals. `bus_low_o` drives the open-drain pull-down. `line_i` is the line level, which the caller must already have synchronised to `clk`.

A small packer collects the results of read slots into a byte, least-significant bit first. A caller that chains eight read slots therefore gets a whole byte together with a valid pulse.

Top module: `owb_slot_engine`

## Requirements
- R1: After a start is accepted, the bus stays released for exactly T_REC_US ticks (1 µs by default) before the slot's low pulse begins.
- R2: A write slot with data bit 1 drives the bus low for exactly T_W1_US ticks (2 µs by default) and then releases it.
- R3: A write slot with data bit 0 drives the bus low for exactly T_W0_US ticks (60 µs by default) and then releases it.
- R4: A read slot drives the bus low for exactly T_RD_US ticks (1 µs by default) and then releases it.
- R5: A read slot latches `line_i` at the edge that falls T_SMP_US ticks (13 µs by default, 12 µs after release) after the falling edge. The line level 1 gives `rbit_o` = 1 and level 0 gives `rbit_o` = 0. The pull-down from a responder that lasts at least T_SMP_US ticks reads as 0, and one that lasts T_SMP_US-1 ticks reads as 1.
- R6: `busy_o` is high from the cycle after acceptance until the slot ends. The slot ends T_REC_US+T_SLOT_US ticks (62 µs by default) after acceptance, with `done_o` high for exactly one cycle as `busy_o` falls.
- R7: A start strobe raised while `busy_o` is high is ignored: the running slot keeps its timing and no further slot follows.
- R8: The result of read slot number i (counted from reset) is written to bit i mod 8 of `rbyte_o`, one cycle after its `done_o`. The byte is cleared before bit 0 is written. `rbyte_vld_o` pulses for one cycle when bit 7 is written.
- R9: After reset, `bus_low_o`, `busy_o`, `done_o`, `rbit_o`, `rbyte_o` and `rbyte_vld_o` are all zero.
- R10: Write slots leave `rbit_o` and `rbyte_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for one slot, accepted only when idle |
| rd_i | input | 1 | Slot kind: 1 read, 0 write |
| wbit_i | input | 1 | Data bit for a write slot |
| busy_o | output | 1 | Slot in progress |
| done_o | output | 1 | One-cycle end-of-slot strobe |
| rbit_o | output | 1 | Bit sampled by the last read slot |
| bus_low_o | output | 1 | Pull-down enable for the open-drain line |
| line_i | input | 1 | Synchronised line level |
| rbyte_o | output | 8 | Read bits packed least-significant first |
| rbyte_vld_o | output | 1 | One-cycle strobe when a byte is complete |

## Verification
The bench builds the engine with a prescaler of 4 clocks per microsecond and keeps the default microsecond widths. A 62 µs slot therefore takes 248 cycles, and ten vectors plus the directed tests fit in a few thousand cycles. Exact cycle counts are still checked for recovery, each low width and the slot end.

A modelled responder holds the line low for a chosen number of microseconds. Hold times of 12, 13 and 14 µs probe the sample edge at its exact cycle. Nine read slots carry the packer past a byte boundary, which reaches the clear-on-bit-0 case.

// File: rtl/owb_pkg.sv
package owb_pkg;
  typedef enum logic [1:0] {
    SLOT_W0 = 2'b00,
    SLOT_W1 = 2'b01,
    SLOT_RD = 2'b10
  } slot_kind_e;
endpackage

// File: rtl/owb_rst_sync.sv
module owb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/owb_tick_gen.sv
module owb_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/owb_slot_ctl.sv
module owb_slot_ctl
  import owb_pkg::*;
#(
  parameter int T_REC_US  = 1,
  parameter int T_W1_US   = 2,
  parameter int T_W0_US   = 60,
  parameter int T_RD_US   = 1,
  parameter int T_SMP_US  = 13,
  parameter int T_SLOT_US = 61
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic rd,
  input  logic wbit,
  input  logic line,
  output logic busy,
  output logic bus_low,
  output logic done,
  output logic done_rd,
  output logic rbit
);
  localparam int END_US = T_REC_US + T_SLOT_US;
  localparam int TW     = $clog2(END_US + 1);
  localparam logic [TW-1:0] L_REC   = TW'(T_REC_US);
  localparam logic [TW-1:0] L_W1    = TW'(T_W1_US);
  localparam logic [TW-1:0] L_W0    = TW'(T_W0_US);
  localparam logic [TW-1:0] L_RD    = TW'(T_RD_US);
  localparam logic [TW-1:0] L_SMP_M = TW'(T_REC_US + T_SMP_US - 1);
  localparam logic [TW-1:0] L_END_M = TW'(END_US - 1);

  logic            busy_q, busy_d;
  logic [TW-1:0]   t_q, t_d;
  slot_kind_e      kind_q, kind_d;
  logic            low_q, low_d;
  logic            done_q, done_d;
  logic            drd_q, drd_d;
  logic            rbit_q, rbit_d;
  logic [TW-1:0]   width;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    t_d    = t_q;
    kind_d = kind_q;
    rbit_d = rbit_q;
    done_d = 1'b0;
    drd_d  = 1'b0;

    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        t_d    = '0;
        kind_d = rd ? SLOT_RD : (wbit ? SLOT_W1 : SLOT_W0);
      end
    end else if (tick) begin
      t_d = t_q + 1'b1;
      if ((kind_q == SLOT_RD) && (t_q == L_SMP_M)) rbit_d = line;
      if (t_q == L_END_M) begin
        busy_d = 1'b0;
        t_d    = '0;
        done_d = 1'b1;
        drd_d  = (kind_q == SLOT_RD);
      end
    end

    case (kind_d)
      SLOT_RD: width = L_RD;
      SLOT_W1: width = L_W1;
      default: width = L_W0;
    endcase
    low_d = busy_d && (t_d >= L_REC) && (t_d < L_REC + width);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      kind_q <= SLOT_W0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      drd_q  <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      t_q    <= t_d;
      kind_q <= kind_d;
      low_q  <= low_d;
      done_q <= done_d;
      drd_q  <= drd_d;
      rbit_q <= rbit_d;
    end
  end

  assign busy    = busy_q;
  assign bus_low = low_q;
  assign done    = done_q;
  assign done_rd = drd_q;
  assign rbit    = rbit_q;
endmodule

// File: rtl/owb_rx_pack.sv
module owb_rx_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o
);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] LAST = IW'(BYTE_W - 1);

  logic [IW-1:0]     idx_q, idx_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              full_q, full_d;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    always_comb begin
      if (push && (idx_q == IW'(g)))      byte_d[g] = bit_in;
      else if (push && (idx_q == '0))     byte_d[g] = 1'b0;
      else                                byte_d[g] = byte_q[g];
    end
  end

  always_comb begin
    idx_d  = idx_q;
    full_d = 1'b0;
    if (push) begin
      idx_d  = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      full_d = (idx_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      byte_q <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      byte_q <= byte_d;
      full_q <= full_d;
    end
  end

  assign byte_o = byte_q;
  assign full_o = full_q;
endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine #(
  parameter int CLK_PER_US = 50,
  parameter int T_REC_US   = 1,
  parameter int T_W1_US    = 2,
  parameter int T_W0_US    = 60,
  parameter int T_RD_US    = 1,
  parameter int T_SMP_US   = 13,
  parameter int T_SLOT_US  = 61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic       wbit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rbit_o,
  output logic       bus_low_o,
  input  logic       line_i,
  output logic [7:0] rbyte_o,
  output logic       rbyte_vld_o
);
  logic srst_n;
  logic tick;
  logic busy;
  logic done_rd;
  logic rbit;

  owb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  owb_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (busy),
    .tick  (tick)
  );

  owb_slot_ctl #(
    .T_REC_US  (T_REC_US),
    .T_W1_US   (T_W1_US),
    .T_W0_US   (T_W0_US),
    .T_RD_US   (T_RD_US),
    .T_SMP_US  (T_SMP_US),
    .T_SLOT_US (T_SLOT_US)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick    (tick),
    .start   (start_i),
    .rd      (rd_i),
    .wbit    (wbit_i),
    .line    (line_i),
    .busy    (busy),
    .bus_low (bus_low_o),
    .done    (done_o),
    .done_rd (done_rd),
    .rbit    (rbit)
  );

  owb_rx_pack #(.BYTE_W(8)) u_pack (
    .clk    (clk),
    .rst_n  (srst_n),
    .push   (done_rd),
    .bit_in (rbit),
    .byte_o (rbyte_o),
    .full_o (rbyte_vld_o)
  );

  assign busy_o = busy;
  assign rbit_o = rbit;
endmodule

// File: rtl/owb_slot_chk.sv
module owb_slot_chk #(
  parameter int CLK_PER_US = 50,
  parameter int T_W1_US    = 2,
  parameter int T_W0_US    = 60,
  parameter int T_RD_US    = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       rbit_o,
  input logic       bus_low_o,
  input logic [7:0] rbyte_o,
  input logic       rbyte_vld_o
);
  int lw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lw_q <= 0;
    else if (bus_low_o) lw_q <= lw_q + 1;
    else                lw_q <= 0;
  end

  // R1: the line is only pulled inside a slot
  p_low_in_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_low_o |-> busy_o);

  // R2/R3/R4: every low pulse has one of the three legal widths
  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_low_o) |-> (lw_q == T_W1_US * CLK_PER_US ||
                          lw_q == T_W0_US * CLK_PER_US ||
                          lw_q == T_RD_US * CLK_PER_US));

  // R6: done is a single-cycle strobe that coincides with busy falling
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7: a slot starts only from idle with a start strobe
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));

  // R8: byte valid only follows a slot end
  p_vld_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rbyte_vld_o |-> $past(done_o));

  // R10: read result moves only during a slot
  p_rbit_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbit_o) |-> busy_o);

  // R10: packed byte moves only right after a slot end
  p_byte_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbyte_o) |-> $past(done_o));
endmodule

bind owb_slot_engine owb_slot_chk #(
  .CLK_PER_US (CLK_PER_US),
  .T_W1_US    (T_W1_US),
  .T_W0_US    (T_W0_US),
  .T_RD_US    (T_RD_US)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rbit_o      (rbit_o),
  .bus_low_o   (bus_low_o),
  .rbyte_o     (rbyte_o),
  .rbyte_vld_o (rbyte_vld_o)
);

// File: tb/tb_owb_slot_engine.sv
module tb_owb_slot_engine;
  localparam int P    = 4;
  localparam int REC  = 1;
  localparam int W1   = 2;
  localparam int W0   = 60;
  localparam int RDW  = 1;
  localparam int SMP  = 13;
  localparam int SLOT = 61;
  localparam int NV   = 10;

  typedef struct packed {
    logic       rd;
    logic       wb;
    logic [7:0] x;
    logic       eb;
  } vec_t;

  // rd, wbit, responder hold (us), expected read bit
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'd0,  1'b0},
    '{1'b0, 1'b0, 8'd0,  1'b0},
    '{1'b1, 1'b0, 8'd0,  1'b1},
    '{1'b1, 1'b0, 8'd13, 1'b0},
    '{1'b1, 1'b0, 8'd12, 1'b1},
    '{1'b1, 1'b0, 8'd40, 1'b0},
    '{1'b1, 1'b0, 8'd0,  1'b1},
    '{1'b1, 1'b0, 8'd14, 1'b0},
    '{1'b1, 1'b0, 8'd11, 1'b1},
    '{1'b1, 1'b0, 8'd13, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic rd_i = 1'b0;
  logic wbit_i = 1'b0;
  logic busy_o, done_o, rbit_o, bus_low_o, line_i, rbyte_vld_o;
  logic [7:0] rbyte_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int slave_x = 0;
  logic cur_rd = 1'b0;
  logic armed = 1'b0;
  int fall_cyc = 0;
  logic slave_low;
  logic finished = 1'b0;

  int ridx = 0;
  logic [7:0] eb = 8'h00;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Responder: holds the line low for slave_x us from the master's falling edge
  always @(negedge clk) begin
    if (done_o) armed <= 1'b0;
    else if (bus_low_o && !armed && cur_rd) begin
      armed    <= 1'b1;
      fall_cyc <= cyc;
    end
  end
  assign slave_low = armed && ((cyc - fall_cyc) < slave_x * P);
  assign line_i    = ~(bus_low_o | slave_low);

  owb_slot_engine #(
    .CLK_PER_US (P),
    .T_REC_US   (REC),
    .T_W1_US    (W1),
    .T_W0_US    (W0),
    .T_RD_US    (RDW),
    .T_SMP_US   (SMP),
    .T_SLOT_US  (SLOT)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_i        (rd_i),
    .wbit_i      (wbit_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rbit_o      (rbit_o),
    .bus_low_o   (bus_low_o),
    .line_i      (line_i),
    .rbyte_o     (rbyte_o),
    .rbyte_vld_o (rbyte_vld_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Runs one slot; inj >= 0 raises an extra start at that offset.
  task automatic run_slot(input logic rd, input logic wb, input int x, input int inj,
                          output int fall_off, output int low_n, output int end_off,
                          output logic busy_seen);
    int a;
    int guard;
    slave_x = rd ? x : 0;
    cur_rd  = rd;
    @(negedge clk);
    start_i = 1'b1; rd_i = rd; wbit_i = wb;
    a = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    busy_seen = busy_o;
    fall_off = -1; low_n = 0; guard = 0;
    while (!done_o && guard < 20000) begin
      if (bus_low_o && fall_off < 0) fall_off = cyc - a;
      if (bus_low_o) low_n++;
      if (inj >= 0 && (cyc - a) == inj) begin
        start_i = 1'b1; rd_i = ~rd; wbit_i = ~wb;
      end else begin
        start_i = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start_i = 1'b0;
    end_off = cyc - a;
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int fo, ln, eo;
    logic bs;
    logic prev_rbit;
    logic [7:0] prev_byte;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    check(bus_low_o == 0 && busy_o == 0 && done_o == 0, "R9 ctl", {bus_low_o, busy_o, done_o}, 0);
    check(rbit_o == 0 && rbyte_o == 0 && rbyte_vld_o == 0, "R9 data", {rbit_o, rbyte_o, rbyte_vld_o}, 0);

    for (int i = 0; i < NV; i++) begin
      int wexp;
      prev_rbit = rbit_o;
      prev_byte = rbyte_o;
      run_slot(VEC[i].rd, VEC[i].wb, int'(VEC[i].x), -1, fo, ln, eo, bs);
      wexp = VEC[i].rd ? RDW : (VEC[i].wb ? W1 : W0);
      check(fo == REC * P, "R1 recovery", fo, REC * P);
      if (VEC[i].rd)      check(ln == wexp * P, "R4 read low", ln, wexp * P);
      else if (VEC[i].wb) check(ln == wexp * P, "R2 write1 low", ln, wexp * P);
      else                check(ln == wexp * P, "R3 write0 low", ln, wexp * P);
      check(eo == (REC + SLOT) * P, "R6 slot end", eo, (REC + SLOT) * P);
      check(bs == 1'b1, "R6 busy", bs, 1);
      if (VEC[i].rd) check(rbit_o == VEC[i].eb, "R5 sample", rbit_o, VEC[i].eb);
      else           check(rbit_o == prev_rbit, "R10 rbit kept", rbit_o, prev_rbit);
      @(negedge clk);
      check(done_o == 0 && busy_o == 0, "R6 done pulse", {done_o, busy_o}, 0);
      if (VEC[i].rd) begin
        if (ridx == 0) eb = 8'h00;
        eb[ridx] = VEC[i].eb;
        check(rbyte_o == eb, "R8 byte", rbyte_o, eb);
        check(rbyte_vld_o == (ridx == 7), "R8 valid", rbyte_vld_o, ridx == 7);
        ridx = (ridx + 1) % 8;
      end else begin
        check(rbyte_o == prev_byte, "R10 byte kept", rbyte_o, prev_byte);
        check(rbyte_vld_o == 0, "R10 no valid", rbyte_vld_o, 0);
      end
    end

    // R8: ninth read opens a new byte, cleared before bit 0 (hold 30 us -> 0)
    run_slot(1'b1, 1'b0, 30, -1, fo, ln, eo, bs);
    @(negedge clk);
    check(rbyte_o == 8'h00, "R8 clear at bit0", rbyte_o, 0);
    check(rbyte_vld_o == 0, "R8 no valid", rbyte_vld_o, 0);

    // R10: write after read keeps the read bit (currently 0)
    run_slot(1'b1, 1'b0, 0, -1, fo, ln, eo, bs);
    check(rbit_o == 1'b1, "R5 read one", rbit_o, 1);
    run_slot(1'b0, 1'b0, 0, -1, fo, ln, eo, bs);
    check(rbit_o == 1'b1, "R10 rbit after write0", rbit_o, 1);

    // R7: start during a write-1 slot is ignored
    run_slot(1'b0, 1'b1, 0, 100, fo, ln, eo, bs);
    check(ln == W1 * P, "R7 width kept", ln, W1 * P);
    check(eo == (REC + SLOT) * P, "R7 end kept", eo, (REC + SLOT) * P);
    begin
      int extra = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy_o || bus_low_o) extra++;
      end
      check(extra == 0, "R7 no second slot", extra, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule